// File: doc/BRIEF.md
# Interleaved Scale-Tile Layout Writer

This block turns a row-major stream of 8-bit block-scale factors into the write sequence for a linear buffer. The buffer holds the scales in tiles of 128 rows by 4 columns. A start pulse latches the logical row count, the column count and a byte base address. The block then walks the padded shape in row-major order and issues one byte write per position. In-range positions take one beat from a valid/ready input stream. Positions added by padding get a zero and take no input. Inside a tile, rows that lie 32 apart share one 16-entry group, so each group of 32 rows reads its scales as regular 4-byte slices. Tiles follow one another in row-major order.

The controller has three states. IDLE waits for a start. An accepted start with a good configuration moves IDLE to RUN. A start with a bad configuration stays in IDLE and raises the error flag. RUN moves to DONE on the last padded write, and DONE returns to IDLE after one cycle.

A separate combinational port maps a buffer entry index back to its tile number and its in-tile row and column. It runs independently of the writer and can be removed with a parameter.

Top module: `scale_tile_writer`

## Requirements
- R1: Inside a tile, the entry for local row r (0..127) and column c (0..3) sits at tile offset (r mod 32)*16 + (r div 32)*4 + c.
- R2: Tiles are 512 entries each and are placed row-major. The tile holding row band tr and column group tc starts at entry (tc + tr*(padded_cols/4))*512. wr_addr is the latched base plus the entry index.
- R3: Rows are padded up to a multiple of 128 and columns up to a multiple of 4. Exactly padded_rows*padded_cols writes are issued, one to each entry. Examples: 256x8 gives 2048 writes and 500x6 gives 4096.
- R4: A padded position is written with 0 and takes no input beat. An in-range position takes exactly one beat, and its byte is written unchanged.
- R5: Writes follow row-major order over the padded shape. When the current position is in range and in_valid is low, no write is issued and the position is held.
- R6: A start whose base address has any of bits [3:0] set is refused. err goes high, and no write and no done follow.
- R7: A start with a row count or column count of zero is refused in the same way as R6.
- R8: done is high for exactly one cycle, the cycle after the last padded write. The block is then idle again.
- R9: A start while RUN or DONE is active is ignored. The run in progress completes with its original configuration.
- R10: The inverse port maps entry index i to inv_tile = i div 512, inv_row = ((i mod 16) div 4)*32 + (i mod 512) div 16 and inv_col = i mod 4.
- R11: After reset, wr_en, in_ready, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion; accepted only in IDLE |
| cfg_rows | input | ROW_W | Logical scale rows |
| cfg_cols | input | COL_W | Logical scale columns |
| cfg_base | input | ADDR_W | Buffer byte base address; must be 16-byte aligned |
| in_valid | input | 1 | Input scale byte present |
| in_data | input | DATA_W | Input scale byte, row-major logical order |
| in_ready | output | 1 | Block takes the input byte this cycle |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer byte address |
| wr_data | output | DATA_W | Byte to write (zero for padding) |
| done | output | 1 | One-cycle pulse after the last write |
| err | output | 1 | Last start was refused; cleared by an accepted start |
| inv_idx | input | ROW_W+COL_W+2 | Entry index for the inverse mapping |
| inv_tile | output | ROW_W+COL_W-7 | Tile number of inv_idx |
| inv_row | output | 7 | Row inside the tile |
| inv_col | output | 2 | Column inside the tile |

## Verification
A wrong position counter or a wrong band base shows up on wr_addr in the very write where it goes wrong, so the bench compares every write against an address it computes from the position. A bad in-range decision shows at once in one of three ways: zero data appears where a stream byte belongs, an input beat is taken on a padding slot, or a write is issued while the stream stalls. A broken end condition shows as a missing done pulse, a done pulse late relative to the last write, or a write count other than the padded size at the end of the run.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int TILE_ROWS  = 128;
    localparam int TILE_COLS  = 4;
    localparam int TILE_SIZE  = TILE_ROWS * TILE_COLS;
    localparam int LANE_ROWS  = 32;
    localparam int ALIGN_BITS = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } wr_state_e;

    // Offset inside one tile: low five row bits pick the 16-entry group,
    // the two upper row bits pick the 4-entry slot, column selects the byte.
    function automatic logic [8:0] tile_slot(input logic [6:0] r, input logic [1:0] c);
        return {r[4:0], r[6:5], c};
    endfunction

endpackage

// File: rtl/scl_walker.sv
module scl_walker #(
    parameter int PR_W  = 17,
    parameter int PC_W  = 13,
    parameter int IDX_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [PR_W-1:0]  prow_lim,
    input  logic [PC_W-1:0]  pcol_lim,
    input  logic [IDX_W-1:0] band_step,
    output logic [PR_W-1:0]  row,
    output logic [PC_W-1:0]  col,
    output logic [IDX_W-1:0] band_base,
    output logic             last
);
    logic [PR_W-1:0]  row_q;
    logic [PC_W-1:0]  col_q;
    logic [IDX_W-1:0] band_q;
    logic             col_end;

    assign col_end   = (col_q == pcol_lim - PC_W'(1));
    assign last      = col_end && (row_q == prow_lim - PR_W'(1));
    assign row       = row_q;
    assign col       = col_q;
    assign band_base = band_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            band_q <= '0;
        end else if (load) begin
            row_q  <= '0;
            col_q  <= '0;
            band_q <= '0;
        end else if (adv) begin
            if (col_end) begin
                col_q <= '0;
                row_q <= row_q + PR_W'(1);
                if (row_q[6:0] == 7'h7f) begin
                    band_q <= band_q + band_step;
                end
            end else begin
                col_q <= col_q + PC_W'(1);
            end
        end
    end

    // R3
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (row_q < prow_lim) && (col_q < pcol_lim));

    // R5
    row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> row_q >= $past(row_q));

endmodule

// File: rtl/scl_fwd_map.sv
module scl_fwd_map #(
    parameter int PC_W  = 13,
    parameter int IDX_W = 30
) (
    input  logic [6:0]       row,
    input  logic [PC_W-1:0]  col,
    input  logic [IDX_W-1:0] band_base,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] group_base;
    logic [IDX_W-1:0] slot;

    always_comb begin
        group_base = IDX_W'(col[PC_W-1:2]) << 9;
        slot       = IDX_W'(scl_pkg::tile_slot(row, col[1:0]));
        idx        = band_base + group_base + slot;
    end

endmodule

// File: rtl/scl_inv_map.sv
module scl_inv_map #(
    parameter int IDX_W = 30
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [IDX_W-10:0] tile,
    output logic [6:0]        row,
    output logic [1:0]        col
);
    always_comb begin
        tile = idx[IDX_W-1:9];
        row  = {idx[3:2], idx[8:4]};
        col  = idx[1:0];
    end

endmodule

// File: rtl/scale_tile_writer.sv
module scale_tile_writer #(
    parameter int ROW_W  = 16,
    parameter int COL_W  = 12,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter bit INV_EN = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ROW_W-1:0]         cfg_rows,
    input  logic [COL_W-1:0]         cfg_cols,
    input  logic [ADDR_W-1:0]        cfg_base,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    output logic                     in_ready,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [DATA_W-1:0]        wr_data,
    output logic                     done,
    output logic                     err,
    input  logic [ROW_W+COL_W+1:0]   inv_idx,
    output logic [ROW_W+COL_W-8:0]   inv_tile,
    output logic [6:0]               inv_row,
    output logic [1:0]               inv_col
);
    import scl_pkg::*;

    localparam int PR_W  = ROW_W + 1;
    localparam int PC_W  = COL_W + 1;
    localparam int IDX_W = PR_W + PC_W;
    localparam int ROW_PAD = TILE_ROWS - 1;
    localparam int COL_PAD = TILE_COLS - 1;

    wr_state_e        state_q, state_d;
    logic [ROW_W-1:0] rows_q;
    logic [COL_W-1:0] cols_q;
    logic [ADDR_W-1:0] base_q;
    logic [PR_W-1:0]  prow_q, prow_d;
    logic [PC_W-1:0]  pcol_q, pcol_d;
    logic [IDX_W-1:0] step_q, step_d;
    logic             err_q;

    logic             cfg_bad, accept, load;
    logic [PR_W-1:0]  cur_row;
    logic [PC_W-1:0]  cur_col;
    logic [IDX_W-1:0] band_base, idx;
    logic             at_last, in_range;

    // configuration decode
    always_comb begin
        cfg_bad = (cfg_base[ALIGN_BITS-1:0] != '0) || (cfg_rows == '0) || (cfg_cols == '0);
        accept  = (state_q == ST_IDLE) && start;
        load    = accept && !cfg_bad;
        prow_d  = (PR_W'(cfg_rows) + PR_W'(ROW_PAD)) & ~PR_W'(ROW_PAD);
        pcol_d  = (PC_W'(cfg_cols) + PC_W'(COL_PAD)) & ~PC_W'(COL_PAD);
        step_d  = IDX_W'(pcol_d[PC_W-1:2]) << 9;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_q <= '0;
            cols_q <= '0;
            base_q <= '0;
            prow_q <= '0;
            pcol_q <= '0;
            step_q <= '0;
            err_q  <= 1'b0;
        end else if (accept) begin
            err_q <= cfg_bad;
            if (!cfg_bad) begin
                rows_q <= cfg_rows;
                cols_q <= cfg_cols;
                base_q <= cfg_base;
                prow_q <= prow_d;
                pcol_q <= pcol_d;
                step_q <= step_d;
            end
        end
    end

    scl_walker #(.PR_W(PR_W), .PC_W(PC_W), .IDX_W(IDX_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .adv       (wr_en),
        .prow_lim  (prow_q),
        .pcol_lim  (pcol_q),
        .band_step (step_q),
        .row       (cur_row),
        .col       (cur_col),
        .band_base (band_base),
        .last      (at_last)
    );

    scl_fwd_map #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fwd (
        .row       (cur_row[6:0]),
        .col       (cur_col),
        .band_base (band_base),
        .idx       (idx)
    );

    generate
        if (INV_EN) begin : g_inv
            scl_inv_map #(.IDX_W(IDX_W)) u_inv (
                .idx  (inv_idx),
                .tile (inv_tile),
                .row  (inv_row),
                .col  (inv_col)
            );
        end else begin : g_no_inv
            logic unused_inv;
            assign unused_inv = ^inv_idx;
            assign inv_tile   = '0;
            assign inv_row    = '0;
            assign inv_col    = '0;
        end
    endgenerate

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_RUN;
            ST_RUN:  if (wr_en && at_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        in_range = (cur_row < PR_W'(rows_q)) && (cur_col < PC_W'(cols_q));
        in_ready = 1'b0;
        wr_en    = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                in_ready = in_range;
                wr_en    = !in_range || in_valid;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        wr_data = in_range ? in_data : '0;
        wr_addr = base_q + ADDR_W'(idx);
        err     = err_q;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en));

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !wr_en && !done && !in_ready);

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !in_ready |-> wr_data == '0);

    // R9
    busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(rows_q) && $stable(cols_q) && $stable(base_q));

endmodule

// File: tb/tb_scale_tile_writer.sv
`timescale 1ns/1ps
module tb_scale_tile_writer;

    localparam int ROW_W = 16;
    localparam int COL_W = 12;
    localparam int ADDR_W = 32;
    localparam int IDX_W = ROW_W + COL_W + 2;
    localparam int SHADOW = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ROW_W-1:0] cfg_rows = '0;
    logic [COL_W-1:0] cfg_cols = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, wr_en, done, err;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0] wr_data;
    logic [IDX_W-1:0] inv_idx = '0;
    logic [IDX_W-10:0] inv_tile;
    logic [6:0] inv_row;
    logic [1:0] inv_col;

    int n_checks = 0;
    int n_errors = 0;
    int hits [SHADOW];

    always #4 clk = ~clk;

    scale_tile_writer dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_base(cfg_base),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err(err),
        .inv_idx(inv_idx), .inv_tile(inv_tile), .inv_row(inv_row), .inv_col(inv_col)
    );

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int fdat(input int r, input int c);
        return ((r * 37 + c * 11 + 5) % 256) | 1;
    endfunction

    function automatic longint exp_idx(input int r, input int c, input int tpr);
        int lr;
        lr = r % 128;
        return longint'(((c / 4) + (r / 128) * tpr) * 512 + (lr % 32) * 16 + (lr / 32) * 4 + (c % 4));
    endfunction

    task automatic test_reset();
        chk(!wr_en && !in_ready && !done && !err, "R11", "outputs after reset",
            {wr_en, in_ready, done, err}, 0);
    endtask

    task automatic run_case(input string nm, input int rows, input int cols,
                            input logic [31:0] base, input bit gap, input bit poke);
        int prows, pcols, tpr, total, r, c, k, nwr, bad_a, bad_d, bad_s;
        int done_cnt, done_cyc, last_cyc, cyc, multi;
        longint ea;
        int ed;
        prows = ((rows + 127) / 128) * 128;
        pcols = ((cols + 3) / 4) * 4;
        tpr = pcols / 4;
        total = prows * pcols;
        r = 0; c = 0; k = 0; nwr = 0; bad_a = 0; bad_d = 0; bad_s = 0;
        done_cnt = 0; done_cyc = -1; last_cyc = -1; cyc = 0; multi = 0;
        for (int i = 0; i < SHADOW; i++) hits[i] = 0;
        @(negedge clk);
        cfg_rows = ROW_W'(rows); cfg_cols = COL_W'(cols); cfg_base = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (cyc < total * 3 + 100 && !(done_cyc >= 0 && cyc > done_cyc + 3)) begin
            if (k < rows * cols) begin
                in_valid = gap ? ((cyc % 3) != 2) : 1'b1;
                in_data = 8'(fdat(k / cols, k % cols));
            end else begin
                in_valid = 1'b0;
            end
            if (poke && cyc == 5) begin
                start = 1'b1; cfg_rows = 1; cfg_cols = 1; cfg_base = 32'h40;
            end else begin
                start = 1'b0;
            end
            #2;
            if (done) begin done_cnt++; done_cyc = cyc; end
            if (in_ready && !in_valid && wr_en) bad_s++;
            if (wr_en) begin
                ea = longint'(base) + exp_idx(r, c, tpr);
                ed = (r < rows && c < cols) ? fdat(r, c) : 0;
                if (longint'(wr_addr) != ea) begin
                    if (bad_a == 0)
                        $display("  %s first address miss at r=%0d c=%0d: %0d vs %0d", nm, r, c, wr_addr, ea);
                    bad_a++;
                end
                if (int'(wr_data) != ed) bad_d++;
                if (longint'(wr_addr) - longint'(base) >= 0 && longint'(wr_addr) - longint'(base) < SHADOW)
                    hits[int'(wr_addr - base)]++;
                nwr++;
                if (nwr == total) last_cyc = cyc;
                if (c == pcols - 1) begin c = 0; r++; end else c++;
            end
            if (in_valid && in_ready) k++;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; in_valid = 1'b0;
        for (int i = 0; i < total && i < SHADOW; i++) if (hits[i] != 1) multi++;
        chk(bad_a == 0, "R1", {nm, " in-tile/tile addresses (R2)"}, bad_a, 0);
        chk(bad_d == 0, "R4", {nm, " data and zero padding"}, bad_d, 0);
        chk(nwr == total, "R3", {nm, " padded write count"}, nwr, total);
        chk(multi == 0, "R3", {nm, " entries not written exactly once"}, multi, 0);
        chk(k == rows * cols, "R4", {nm, " input beats consumed"}, k, rows * cols);
        chk(bad_s == 0, "R5", {nm, " write during stream stall"}, bad_s, 0);
        chk(done_cnt == 1 && done_cyc == last_cyc + 1, "R8", {nm, " done pulse cycle"},
            done_cyc, last_cyc + 1);
        chk(!err, poke ? "R9" : "R6", {nm, " err clear after good start"}, err, 0);
    endtask

    task automatic run_err(input string nm, input string req, input int rows, input int cols,
                           input logic [31:0] base);
        int seen;
        seen = 0;
        @(negedge clk);
        cfg_rows = ROW_W'(rows); cfg_cols = COL_W'(cols); cfg_base = base; start = 1'b1;
        in_valid = 1'b1; in_data = 8'h5a;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 600; i++) begin
            #2;
            if (wr_en || done || in_ready) seen++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(err, req, {nm, " err flag"}, err, 1);
        chk(seen == 0, req, {nm, " activity after refused start"}, seen, 0);
    endtask

    task automatic test_inverse();
        int idxs [5] = '{4, 17, 515, 511, 1234};
        for (int i = 0; i < 5; i++) begin
            int ix, er;
            ix = idxs[i];
            inv_idx = IDX_W'(ix);
            #1;
            er = ((ix % 16) / 4) * 32 + (ix % 512) / 16;
            chk(int'(inv_tile) == ix / 512, "R10", "inverse tile", inv_tile, ix / 512);
            chk(int'(inv_row) == er && int'(inv_col) == ix % 4, "R10", "inverse row/col",
                inv_row * 4 + inv_col, er * 4 + ix % 4);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #20;
        @(negedge clk);
        #2;
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_case("4x2", 4, 2, 32'h1000, 1'b0, 1'b0);
        run_case("256x8", 256, 8, 32'h0, 1'b1, 1'b0);
        run_case("500x6", 500, 6, 32'h2000, 1'b1, 1'b0);
        run_err("misaligned base", "R6", 4, 4, 32'h1008);
        run_case("130x5 busy start", 130, 5, 32'h30, 1'b0, 1'b1);
        run_err("zero rows", "R7", 0, 4, 32'h0);
        run_err("zero cols", "R7", 8, 0, 32'h0);
        run_case("1x1 after error", 1, 1, 32'h10, 1'b1, 1'b0);
        test_inverse();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule